// File: doc/BRIEF.md
# Note Duration Counter Unit

This block keeps track of how long each of four tone channels keeps sounding: two pulse channels, one triangle channel and one noise channel. Software-style byte writes arrive on a small write port that selects a channel (or the shared channel-enable register) and a register index inside that channel. A separate tick input, qualified by a kind bit, paces the counting. The block reports whether each channel is switched on and sounding, the remaining duration count of every channel, the triangle's linear counter and its reload flag, and the stored enable bit of the sample-playback channel.

A write to the last register (index 3) of a channel loads its duration counter from a fixed 32-entry table, doubled. The load also switches the channel on, but only when the enable register allows it. Duration counters count down on ticks of kind 0 unless the channel's halt bit holds them. The triangle also has a linear counter that is refilled from its register 0 while a reload flag is set, and counts down otherwise.

Top module: `note_length_unit`

## Requirements
- R1: A write to index 3 of channel unit c (0 pulse A, 1 pulse B, 2 triangle, 3 noise) loads that channel's duration counter with twice the table entry picked by data bits 7:3. Table: entry 1 is 127; an odd entry n from 3 upward is (n-1)/2; the even entries 0,2,...,30 are, in order, 5,10,19,40,80,30,7,13,6,12,24,48,96,36,8,16.
- R2: That index-3 write switches the channel on only if the channel's bit of the enable register is set (pulse A bit 0, pulse B bit 1, triangle bit 2, noise bit 3). With the bit clear, the counter still loads but the channel stays off.
- R3: A write to the enable register (unit 4) with a channel's bit at 0 switches that channel off and clears its duration counter. For the triangle it also clears the linear counter and the reload flag.
- R4: The halt bit is data bit 5 of an index-0 write for pulse and noise channels, and data bit 7 of an index-0 write for the triangle.
- R5: On a tick with tick_kind 0, every channel that is on, not halted and has a nonzero duration counter decrements it by one. A tick with tick_kind 1 leaves all duration counters unchanged, and so does a switched-off channel.
- R6: On any tick while the triangle is on, a set reload flag loads the linear counter with bits 6:0 of the last triangle index-0 write. A clear reload flag lets a nonzero linear counter decrement. While the triangle is off, ticks leave the linear counter alone.
- R7: After that linear update, the reload flag clears if the triangle is not halted and the new linear value is nonzero. A triangle index-3 write sets the reload flag.
- R8: active[c] is 1 exactly when channel c is on and its duration counter is nonzero.
- R9: sample_en holds data bit 4 of the last enable-register write.
- R10: When a write and a tick share a cycle, the tick acts on the previous state and the write is applied on top. An index-3 write during a kind-0 tick leaves the full loaded value.
- R11: Writes to indices 1 and 2, and writes with unit codes 5 to 7, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| wr_unit | input | 3 | 0 pulse A, 1 pulse B, 2 triangle, 3 noise, 4 enable register |
| wr_idx | input | 2 | Register index inside a channel |
| wr_byte | input | 8 | Write data |
| tick | input | 1 | Counting tick |
| tick_kind | input | 1 | 0: duration and linear tick, 1: linear-only tick |
| len_flat | output | 4*LEN_W | Duration counters, channel c at bits [c*LEN_W +: LEN_W] |
| lin_cnt | output | LIN_W | Triangle linear counter |
| lin_reload | output | 1 | Triangle reload flag |
| chan_en | output | 4 | Channel switched-on bits |
| active | output | 4 | Channel on with nonzero duration counter |
| sample_en | output | 1 | Stored sample-playback enable bit |

## Verification
Every result is registered once, so a write or tick presented before a rising edge is visible on all outputs just after that edge, with no further delay for any channel or for the linear counter. The driver applies one stimulus per cycle at the falling edge and queues the outputs it expects after the next rising edge. The monitor takes one entry 1 ns after each rising edge and compares all outputs at once, so every check samples the single cycle where the result is due. Shared-cycle writes and ticks, and writes that must change nothing, go through the same queue.

// File: rtl/nlu_pkg.sv
package nlu_pkg;

    localparam logic [2:0] UNIT_ENABLE = 3'd4;
    localparam logic [1:0] IDX_CTRL    = 2'd0;
    localparam logic [1:0] IDX_LOAD    = 2'd3;

    // Base duration before doubling, selected by write data bits 7:3.
    function automatic logic [6:0] dur_base(input logic [4:0] sel);
        logic [6:0] r;
        if (sel[0]) begin
            r = (sel[4:1] == 4'd0) ? 7'd127 : {3'b000, sel[4:1]};
        end else begin
            case (sel[4:1])
                4'd0:    r = 7'd5;
                4'd1:    r = 7'd10;
                4'd2:    r = 7'd19;
                4'd3:    r = 7'd40;
                4'd4:    r = 7'd80;
                4'd5:    r = 7'd30;
                4'd6:    r = 7'd7;
                4'd7:    r = 7'd13;
                4'd8:    r = 7'd6;
                4'd9:    r = 7'd12;
                4'd10:   r = 7'd24;
                4'd11:   r = 7'd48;
                4'd12:   r = 7'd96;
                4'd13:   r = 7'd36;
                4'd14:   r = 7'd8;
                default: r = 7'd16;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/nlu_len_chan.sv
module nlu_len_chan #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_len,
    input  logic             wr_ctrl,
    input  logic             halt_din,
    input  logic             wr_load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             gate,
    input  logic             kill,
    output logic [LEN_W-1:0] len,
    output logic             en
);

    typedef struct packed {
        logic             en;
        logic             halt;
        logic [LEN_W-1:0] len;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // tick first, on the previous state
        if (tick_len && st_q.en && !st_q.halt && (st_q.len != '0)) begin
            st_d.len = st_q.len - 1'b1;
        end
        // writes on top
        if (wr_ctrl) begin
            st_d.halt = halt_din;
        end
        if (wr_load) begin
            st_d.len = load_val;
            if (gate) begin
                st_d.en = 1'b1;
            end
        end
        if (kill) begin
            st_d.en  = 1'b0;
            st_d.len = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len = st_q.len;
    assign en  = st_q.en;

endmodule

// File: rtl/nlu_tri_linear.sv
module nlu_tri_linear #(
    parameter int LIN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             tri_on,
    input  logic             wr_ctrl,
    input  logic             halt_din,
    input  logic [LIN_W-1:0] val_din,
    input  logic             set_reload,
    input  logic             kill,
    output logic [LIN_W-1:0] cnt,
    output logic             reload
);

    typedef struct packed {
        logic             reload;
        logic             halt;
        logic [LIN_W-1:0] val;
        logic [LIN_W-1:0] cnt;
    } lin_st_t;

    lin_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick && tri_on) begin
            if (st_q.reload) begin
                st_d.cnt = st_q.val;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            if (!st_q.halt && (st_d.cnt != '0)) begin
                st_d.reload = 1'b0;
            end
        end
        if (wr_ctrl) begin
            st_d.halt = halt_din;
            st_d.val  = val_din;
        end
        if (set_reload) begin
            st_d.reload = 1'b1;
        end
        if (kill) begin
            st_d.cnt    = '0;
            st_d.reload = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.cnt;
    assign reload = st_q.reload;

endmodule

// File: rtl/note_length_unit.sv
module note_length_unit #(
    parameter int LEN_W = 8,
    parameter int LIN_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [2:0]         wr_unit,
    input  logic [1:0]         wr_idx,
    input  logic [7:0]         wr_byte,
    input  logic               tick,
    input  logic               tick_kind,
    output logic [4*LEN_W-1:0] len_flat,
    output logic [LIN_W-1:0]   lin_cnt,
    output logic               lin_reload,
    output logic [3:0]         chan_en,
    output logic [3:0]         active,
    output logic               sample_en
);
    import nlu_pkg::*;

    localparam int NUM_CH  = 4;
    localparam int TRI_CH  = 2;
    localparam int MASK_W  = NUM_CH + 1;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
    } top_st_t;

    top_st_t top_d, top_q;

    logic             mask_wr;
    logic             tick_len;
    logic [LEN_W-1:0] load_val;
    logic [NUM_CH-1:0] kill;

    assign mask_wr  = wr_stb && (wr_unit == UNIT_ENABLE);
    assign tick_len = tick && !tick_kind;
    assign load_val = LEN_W'({dur_base(wr_byte[7:3]), 1'b0});

    always_comb begin
        top_d = top_q;
        if (mask_wr) begin
            top_d.mask = wr_byte[MASK_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int HALT_POS = (c == TRI_CH) ? 7 : 5;
        logic             sel;
        logic [LEN_W-1:0] len_w;
        logic             en_w;

        assign sel     = wr_stb && (wr_unit == 3'(c));
        assign kill[c] = mask_wr && !wr_byte[c];

        nlu_len_chan #(.LEN_W(LEN_W)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_len (tick_len),
            .wr_ctrl  (sel && (wr_idx == IDX_CTRL)),
            .halt_din (wr_byte[HALT_POS]),
            .wr_load  (sel && (wr_idx == IDX_LOAD)),
            .load_val (load_val),
            .gate     (top_q.mask[c]),
            .kill     (kill[c]),
            .len      (len_w),
            .en       (en_w)
        );

        assign len_flat[c*LEN_W +: LEN_W] = len_w;
        assign chan_en[c] = en_w;
        assign active[c]  = en_w && (len_w != '0);
    end

    logic tri_sel;
    assign tri_sel = wr_stb && (wr_unit == 3'(TRI_CH));

    nlu_tri_linear #(.LIN_W(LIN_W)) i_lin (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .tri_on     (chan_en[TRI_CH]),
        .wr_ctrl    (tri_sel && (wr_idx == IDX_CTRL)),
        .halt_din   (wr_byte[7]),
        .val_din    (wr_byte[LIN_W-1:0]),
        .set_reload (tri_sel && (wr_idx == IDX_LOAD)),
        .kill       (kill[TRI_CH]),
        .cnt        (lin_cnt),
        .reload     (lin_reload)
    );

    assign sample_en = top_q.mask[NUM_CH];

endmodule

// File: rtl/nlu_checker.sv
module nlu_checker #(
    parameter int LEN_W = 8,
    parameter int LIN_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_stb,
    input logic [2:0]         wr_unit,
    input logic [1:0]         wr_idx,
    input logic [4:0]         mask_in,
    input logic               tick,
    input logic               tick_kind,
    input logic [4*LEN_W-1:0] len_flat,
    input logic [LIN_W-1:0]   lin_cnt,
    input logic               lin_reload,
    input logic [3:0]         chan_en,
    input logic [3:0]         active,
    input logic               sample_en
);

    p_len_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb && !(tick && !tick_kind)) |=> $stable(len_flat));

    p_lin_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb && !tick) |=> ($stable(lin_cnt) && $stable(lin_reload)));

    p_tri_kill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_unit == 3'd4 && !mask_in[2]) |=> (lin_cnt == '0 && !lin_reload));

    p_reload_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_unit == 3'd2 && wr_idx == 2'd3) |=> lin_reload);

    p_load_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_unit == 3'd3 && wr_idx == 2'd3) |=> (len_flat[3*LEN_W +: LEN_W] != '0));

    p_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_unit == 3'd4) |=> (sample_en == $past(mask_in[4])));

    for (genvar c = 0; c < 4; c++) begin : g_chk
        p_kill_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb && wr_unit == 3'd4 && !mask_in[c])
            |=> (len_flat[c*LEN_W +: LEN_W] == '0 && !chan_en[c]));

        p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(chan_en[c]) |-> $past(wr_stb && wr_unit == 3'(c) && wr_idx == 2'd3));

        p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_en[c] |-> !active[c]);
    end

endmodule

bind note_length_unit nlu_checker #(.LEN_W(LEN_W), .LIN_W(LIN_W)) i_nlu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_unit    (wr_unit),
    .wr_idx     (wr_idx),
    .mask_in    (wr_byte[4:0]),
    .tick       (tick),
    .tick_kind  (tick_kind),
    .len_flat   (len_flat),
    .lin_cnt    (lin_cnt),
    .lin_reload (lin_reload),
    .chan_en    (chan_en),
    .active     (active),
    .sample_en  (sample_en)
);

// File: tb/test_note_length_unit.sv
`timescale 1ns/1ps
module test_note_length_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [2:0]  wr_unit = '0;
    logic [1:0]  wr_idx = '0;
    logic [7:0]  wr_byte = '0;
    logic        tick = 1'b0;
    logic        tick_kind = 1'b0;
    logic [31:0] len_flat;
    logic [6:0]  lin_cnt;
    logic        lin_reload;
    logic [3:0]  chan_en;
    logic [3:0]  active;
    logic        sample_en;

    always #2.5 clk = ~clk;

    note_length_unit i_note_length_unit (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_unit(wr_unit),
        .wr_idx(wr_idx), .wr_byte(wr_byte), .tick(tick), .tick_kind(tick_kind),
        .len_flat(len_flat), .lin_cnt(lin_cnt), .lin_reload(lin_reload),
        .chan_en(chan_en), .active(active), .sample_en(sample_en)
    );

    typedef struct {
        logic [31:0] len;
        logic [6:0]  lin;
        logic        rel;
        logic [3:0]  en;
        logic [3:0]  act;
        logic        samp;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_bad    = 0;
    bit   done     = 0;

    int durtab[32] = '{5, 127, 10, 1, 19, 2, 40, 3, 80, 4, 30, 5, 7, 6, 13, 7,
                       6, 8, 12, 9, 24, 10, 48, 11, 96, 12, 36, 13, 8, 14, 16, 15};

    // reference model state
    int       m_len[4];
    bit       m_on[4];
    bit       m_halt[4];
    int       m_lin = 0;
    bit       m_rel = 0;
    int       m_linval = 0;
    bit [4:0] m_mask = '0;

    task automatic step(input logic stb, input logic [2:0] unit, input logic [1:0] idx,
                        input logic [7:0] data, input logic tk, input logic kind,
                        input string tag);
        exp_t e;
        @(negedge clk);
        wr_stb = stb; wr_unit = unit; wr_idx = idx; wr_byte = data;
        tick = tk; tick_kind = kind;
        if (tk) begin
            bit tri_on;
            tri_on = m_on[2];
            for (int c = 0; c < 4; c++) begin
                if (!kind && m_on[c] && !m_halt[c] && m_len[c] != 0) m_len[c]--;
            end
            if (tri_on) begin
                if (m_rel) m_lin = m_linval;
                else if (m_lin != 0) m_lin--;
                if (!m_halt[2] && m_lin != 0) m_rel = 0;
            end
        end
        if (stb) begin
            if (unit == 3'd4) begin
                m_mask = data[4:0];
                for (int c = 0; c < 4; c++) begin
                    if (!data[c]) begin
                        m_on[c] = 0; m_len[c] = 0;
                        if (c == 2) begin m_lin = 0; m_rel = 0; end
                    end
                end
            end else if (unit < 3'd4) begin
                if (idx == 2'd0) begin
                    m_halt[unit] = (unit == 3'd2) ? data[7] : data[5];
                    if (unit == 3'd2) m_linval = int'(data[6:0]);
                end
                if (idx == 2'd3) begin
                    m_len[unit] = durtab[data[7:3]] * 2;
                    if (m_mask[unit]) m_on[unit] = 1;
                    if (unit == 3'd2) m_rel = 1;
                end
            end
        end
        for (int c = 0; c < 4; c++) begin
            e.len[c*8 +: 8] = 8'(m_len[c]);
            e.en[c]  = m_on[c];
            e.act[c] = m_on[c] && (m_len[c] != 0);
        end
        e.lin  = 7'(m_lin);
        e.rel  = m_rel;
        e.samp = m_mask[4];
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [2:0] unit, input logic [1:0] idx, input logic [7:0] data,
                      input string tag);
        step(1'b1, unit, idx, data, 1'b0, 1'b0, tag);
    endtask

    task automatic tk(input logic kind, input string tag);
        step(1'b0, 3'd0, 2'd0, 8'h00, 1'b1, kind, tag);
    endtask

    // monitor: one expectation per rising edge, sampled 1 ns after it
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if ({len_flat, lin_cnt, lin_reload, chan_en, active, sample_en} !==
                {e.len, e.lin, e.rel, e.en, e.act, e.samp}) begin
                n_bad++;
                $display("FAIL %s: actual len=%h lin=%0d rel=%b en=%b act=%b samp=%b expected len=%h lin=%0d rel=%b en=%b act=%b samp=%b",
                         e.tag, len_flat, lin_cnt, lin_reload, chan_en, active, sample_en,
                         e.len, e.lin, e.rel, e.en, e.act, e.samp);
            end
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            m_len[c] = 0; m_on[c] = 0; m_halt[c] = 0;
        end
        repeat (3) @(negedge clk);
        n_checks++;
        if ({len_flat, lin_cnt, lin_reload, chan_en, active, sample_en} !== '0) begin
            n_bad++;
            $display("FAIL reset: actual len=%h lin=%0d en=%b act=%b samp=%b expected all zero",
                     len_flat, lin_cnt, chan_en, active, sample_en);
        end
        rst_n = 1'b1;

        wr(3'd4, 2'd0, 8'h1F, "R9 enable all");
        wr(3'd0, 2'd3, 8'h00, "R1 pulse A entry 0");
        wr(3'd1, 2'd3, 8'h08, "R1 pulse B entry 1");
        wr(3'd3, 2'd3, 8'hF8, "R1 noise entry 31");
        wr(3'd2, 2'd0, 8'h85, "R4 triangle halt and value");
        wr(3'd2, 2'd3, 8'h10, "R7 triangle load sets reload");
        tk(1'b1, "R5 kind 1 tick keeps lengths, R6 reload");
        tk(1'b0, "R5 kind 0 tick decrements, halted triangle holds");
        wr(3'd2, 2'd0, 8'h05, "R4 triangle unhalt");
        tk(1'b1, "R7 reload flag clears");
        tk(1'b1, "R6 linear decrement");
        tk(1'b0, "R5 triangle now counts");
        wr(3'd0, 2'd0, 8'h20, "R4 pulse A halt bit 5");
        tk(1'b0, "R4 halted pulse A holds");
        wr(3'd4, 2'd0, 8'h1E, "R3 pulse A switched off");
        wr(3'd0, 2'd3, 8'h50, "R2 load with enable bit clear");
        tk(1'b0, "R5 off channel holds count");
        wr(3'd4, 2'd0, 8'h1B, "R3 triangle cleared");
        tk(1'b1, "R6 off triangle ignores tick");
        wr(3'd1, 2'd1, 8'hFF, "R11 index 1 ignored");
        wr(3'd3, 2'd2, 8'hFF, "R11 index 2 ignored");
        wr(3'd5, 2'd3, 8'h00, "R11 unit 5 ignored");
        wr(3'd7, 2'd0, 8'h00, "R11 unit 7 ignored");
        step(1'b1, 3'd3, 2'd3, 8'h60, 1'b1, 1'b0, "R10 load during tick");
        wr(3'd3, 2'd3, 8'h18, "R1 noise entry 3");
        tk(1'b0, "R8 noise 1 left");
        tk(1'b0, "R8 noise reaches zero");
        tk(1'b0, "R8 noise stays zero");
        wr(3'd4, 2'd0, 8'h0F, "R9 sample bit clear");
        wr(3'd2, 2'd0, 8'h03, "R6 triangle value 3");
        wr(3'd2, 2'd3, 8'h20, "R2 triangle on");
        for (int i = 0; i < 5; i++) tk(1'b1, "R6 linear count down");
        wr(3'd2, 2'd0, 8'h80, "R7 triangle halt with value 0");
        wr(3'd2, 2'd3, 8'h20, "R7 reload set");
        tk(1'b1, "R7 zero linear keeps reload");
        step(1'b1, 3'd2, 2'd0, 8'h02, 1'b1, 1'b1, "R10 control write during tick");
        tk(1'b1, "R6 reload from new value");

        @(negedge clk);
        wr_stb = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule